// File: doc/BRIEF.md
# Boot Program Copy Engine

This block keeps a short boot program in a 1 KB always-on retention memory. When asked, it copies a run of 32-bit words from that memory into a processor's instruction memory. A host fills the retention memory through a plain register bus. It then programs a source byte offset, a destination byte address and a word count, and sets a go bit. The go bit stays set while the copy runs, and the host polls it until the hardware clears it.

An auto-run enable bit lets the same copy run again with no host action. A single-cycle pulse on the power-up input then starts the copy with the parameters already held. The instruction-memory side is a write port with a ready input. The engine issues at most one word per cycle and waits whenever the port is not ready.

Top module: `boot_copy_engine`

## Requirements
- R1: After reset, the control register (offset 0x000) and the status register (offset 0x010) read 0, and no instruction-memory write is issued.
- R2: Writing the control register with bit 31 set while idle starts a copy. Bit 31 reads 1 while the copy runs and returns to 0 when it ends. Writing bit 31 during a copy does not restart it.
- R3: A copy of N words writes retention word ((src/4 + i) mod 256) to instruction byte address dst + 4*i, for i = 0..N-1 in ascending order. The source offset is at 0x004, the destination at 0x008 and the 9-bit count at 0x00C.
- R4: Status bit 0 becomes 1 when a copy ends and returns to 0 in the cycle after a new copy starts.
- R5: A word count of 0 ends the copy after one busy cycle, with no instruction-memory write, and sets the status done bit.
- R6: While the write port's ready input is low, the pending address and data are held and the copy does not advance.
- R7: Host writes to the source, destination or count registers during a copy are ignored; each reads back its previous value.
- R8: Control bit 30 is a readable auto-run enable. With it set, a power-up pulse while idle starts a copy with the held parameters. With it clear, a power-up pulse starts nothing.
- R9: The retention memory is read and written as words at block offsets 0x400 to 0x7FF, and a copy leaves its contents unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register/memory write strobe |
| reg_addr | input | 12 | Byte offset within the block |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| pwr_up | input | 1 | Power-up event pulse |
| imem_we | output | 1 | Instruction-memory write request |
| imem_addr | output | 16 | Instruction-memory byte address |
| imem_wdata | output | 32 | Instruction-memory write data |
| imem_ready | input | 1 | Instruction memory accepts the write this cycle |

## Verification
The hardest situation to reach from the ports is a host write arriving while a copy is still in flight. With the port always ready, a copy lasts only a few cycles, which leaves too little time for a bus write and a readback. The stimulus therefore holds the ready input low after launching a copy. While the engine is frozen, it writes new parameters and a second go, reads the registers back, and only then releases ready and checks where the words landed. A separate pass drives ready from a pseudo-random pattern, so stalls fall on the first, middle and last words.

// File: rtl/bce_pkg.sv
package bce_pkg;
    // Block-relative register offsets
    localparam int OFF_CTRL   = 'h000;
    localparam int OFF_SRC    = 'h004;
    localparam int OFF_DST    = 'h008;
    localparam int OFF_CNT    = 'h00C;
    localparam int OFF_STAT   = 'h010;
    // Control bit positions
    localparam int CTRL_GO    = 31;
    localparam int CTRL_AUTO  = 30;
    // Word step on the instruction-memory side, in bytes
    localparam int WORD_BYTES = 4;
endpackage

// File: rtl/bce_ret_ram.sv
module bce_ret_ram #(
    parameter int WORDS = 256,
    parameter int DW    = 32,
    localparam int AW   = $clog2(WORDS)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr_a,
    output logic [DW-1:0] rdata_a,
    input  logic [AW-1:0] raddr_b,
    output logic [DW-1:0] rdata_b
);
    logic [DW-1:0] mem_q [WORDS];

    always_ff @(posedge clk) begin
        if (we) mem_q[waddr] <= wdata;
    end

    assign rdata_a = mem_q[raddr_a];
    assign rdata_b = mem_q[raddr_b];
endmodule

// File: rtl/bce_ctrl_regs.sv
module bce_ctrl_regs #(
    parameter int REG_AW  = 12,
    parameter int IMEM_AW = 16,
    parameter int RAM_AW  = 8,
    localparam int CNT_W  = RAM_AW + 1,
    localparam int WIN_W  = REG_AW - RAM_AW - 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_wr,
    input  logic [REG_AW-1:0]  reg_addr,
    input  logic [31:0]        reg_wdata,
    input  logic               busy,
    output logic [RAM_AW-1:0]  src_idx,
    output logic [IMEM_AW-1:0] dst_addr,
    output logic [CNT_W-1:0]   word_cnt,
    output logic               auto_en,
    output logic               go_req,
    output logic               ram_sel,
    output logic               ram_we
);
    import bce_pkg::*;

    typedef struct packed {
        logic [RAM_AW-1:0]  src;
        logic [IMEM_AW-1:0] dst;
        logic [CNT_W-1:0]   cnt;
        logic               auto_run;
    } regs_t;

    regs_t r_q, r_d;
    logic  hit_ctrl, hit_src, hit_dst, hit_cnt;

    assign hit_ctrl = reg_wr && (reg_addr == REG_AW'(OFF_CTRL));
    assign hit_src  = reg_wr && (reg_addr == REG_AW'(OFF_SRC));
    assign hit_dst  = reg_wr && (reg_addr == REG_AW'(OFF_DST));
    assign hit_cnt  = reg_wr && (reg_addr == REG_AW'(OFF_CNT));
    assign ram_sel  = (reg_addr[REG_AW-1:RAM_AW+2] == WIN_W'(1));

    always_comb begin
        r_d = r_q;
        if (hit_ctrl)          r_d.auto_run = reg_wdata[CTRL_AUTO];
        if (hit_src && !busy)  r_d.src = reg_wdata[RAM_AW+1:2];
        if (hit_dst && !busy)  r_d.dst = reg_wdata[IMEM_AW-1:0];
        if (hit_cnt && !busy)  r_d.cnt = reg_wdata[CNT_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign src_idx  = r_q.src;
    assign dst_addr = r_q.dst;
    assign word_cnt = r_q.cnt;
    assign auto_en  = r_q.auto_run;
    assign go_req   = hit_ctrl && reg_wdata[CTRL_GO] && !busy;
    assign ram_we   = reg_wr && ram_sel;

    // R7: parameters stay put under a running copy
    a_r7_src_locked: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && hit_src) |=> $stable(src_idx));
    a_r7_cnt_locked: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && hit_cnt) |=> $stable(word_cnt));
endmodule

// File: rtl/bce_copy_fsm.sv
module bce_copy_fsm #(
    parameter int IMEM_AW = 16,
    parameter int RAM_AW  = 8,
    localparam int CNT_W  = RAM_AW + 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [RAM_AW-1:0]  src_idx,
    input  logic [IMEM_AW-1:0] dst_addr,
    input  logic [CNT_W-1:0]   word_cnt,
    input  logic               imem_ready,
    output logic               busy,
    output logic               done,
    output logic [RAM_AW-1:0]  rd_idx,
    output logic               imem_we,
    output logic [IMEM_AW-1:0] imem_addr
);
    import bce_pkg::*;

    typedef struct packed {
        logic               busy;
        logic               done;
        logic [RAM_AW-1:0]  idx;
        logic [IMEM_AW-1:0] addr;
        logic [CNT_W-1:0]   rem;
    } fsm_t;

    fsm_t s_q, s_d;

    always_comb begin
        s_d = s_q;
        if (start) begin
            s_d.busy = 1'b1;
            s_d.done = 1'b0;
            s_d.idx  = src_idx;
            s_d.addr = dst_addr;
            s_d.rem  = word_cnt;
        end else if (s_q.busy) begin
            if (s_q.rem == '0) begin
                s_d.busy = 1'b0;
                s_d.done = 1'b1;
            end else if (imem_ready) begin
                s_d.idx  = s_q.idx + 1'b1;
                s_d.addr = s_q.addr + IMEM_AW'(WORD_BYTES);
                s_d.rem  = s_q.rem - 1'b1;
                if (s_q.rem == CNT_W'(1)) begin
                    s_d.busy = 1'b0;
                    s_d.done = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign busy      = s_q.busy;
    assign done      = s_q.done;
    assign rd_idx    = s_q.idx;
    assign imem_addr = s_q.addr;
    assign imem_we   = s_q.busy && (s_q.rem != '0);

    // R2: running and finished are never reported together
    a_r2_busy_done_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done));
    // R4: a launch clears the done flag
    a_r4_done_clears: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (busy && !done));
    // R5: an empty copy issues no write
    a_r5_zero_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        (start && word_cnt == '0) |=> !imem_we);
    // R6: a refused write is held unchanged
    a_r6_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (imem_we && !imem_ready) |=> (imem_we && $stable(imem_addr) && $stable(rd_idx)));
    // R3: accepted words advance the address by one word
    a_r3_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
        (imem_we && imem_ready) |=>
            (!imem_we || imem_addr == $past(imem_addr) + IMEM_AW'(WORD_BYTES)));
endmodule

// File: rtl/boot_copy_engine.sv
module boot_copy_engine #(
    parameter int REG_AW    = 12,
    parameter int RAM_BYTES = 1024,
    parameter int IMEM_AW   = 16,
    localparam int RAM_WORDS = RAM_BYTES / 4,
    localparam int RAM_AW    = $clog2(RAM_WORDS),
    localparam int CNT_W     = RAM_AW + 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_wr,
    input  logic [REG_AW-1:0]  reg_addr,
    input  logic [31:0]        reg_wdata,
    output logic [31:0]        reg_rdata,
    input  logic               pwr_up,
    output logic               imem_we,
    output logic [IMEM_AW-1:0] imem_addr,
    output logic [31:0]        imem_wdata,
    input  logic               imem_ready
);
    import bce_pkg::*;

    logic [RAM_AW-1:0]  src_idx, rd_idx;
    logic [IMEM_AW-1:0] dst_addr;
    logic [CNT_W-1:0]   word_cnt;
    logic               auto_en, go_req, ram_sel, ram_we, busy, done, launch;
    logic [31:0]        ram_host_rd;

    bce_ctrl_regs #(.REG_AW(REG_AW), .IMEM_AW(IMEM_AW), .RAM_AW(RAM_AW)) u_regs (
        .clk, .rst_n, .reg_wr, .reg_addr, .reg_wdata, .busy,
        .src_idx, .dst_addr, .word_cnt, .auto_en, .go_req, .ram_sel, .ram_we
    );

    bce_ret_ram #(.WORDS(RAM_WORDS), .DW(32)) u_ram (
        .clk,
        .we      (ram_we),
        .waddr   (reg_addr[RAM_AW+1:2]),
        .wdata   (reg_wdata),
        .raddr_a (reg_addr[RAM_AW+1:2]),
        .rdata_a (ram_host_rd),
        .raddr_b (rd_idx),
        .rdata_b (imem_wdata)
    );

    assign launch = go_req || (pwr_up && auto_en && !busy);

    bce_copy_fsm #(.IMEM_AW(IMEM_AW), .RAM_AW(RAM_AW)) u_fsm (
        .clk, .rst_n, .start(launch), .src_idx, .dst_addr, .word_cnt,
        .imem_ready, .busy, .done, .rd_idx, .imem_we, .imem_addr
    );

    always_comb begin
        reg_rdata = '0;
        if (ram_sel) reg_rdata = ram_host_rd;
        else begin
            case (reg_addr)
                REG_AW'(OFF_CTRL): begin
                    reg_rdata[CTRL_GO]   = busy;
                    reg_rdata[CTRL_AUTO] = auto_en;
                end
                REG_AW'(OFF_SRC):  reg_rdata = 32'({src_idx, 2'b00});
                REG_AW'(OFF_DST):  reg_rdata = 32'(dst_addr);
                REG_AW'(OFF_CNT):  reg_rdata = 32'(word_cnt);
                REG_AW'(OFF_STAT): reg_rdata[0] = done;
                default:           reg_rdata = '0;
            endcase
        end
    end

    // R8: a power-up pulse with auto-run clear launches nothing
    a_r8_no_auto: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_up && !auto_en && !busy && !go_req) |=> !busy);
endmodule

// File: tb/boot_copy_engine_bench.sv
module boot_copy_engine_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [11:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        pwr_up = 1'b0;
    logic        imem_we;
    logic [15:0] imem_addr;
    logic [31:0] imem_wdata;
    logic        imem_ready = 1'b1;

    int checks = 0;
    int fails  = 0;
    int wcnt   = 0;
    int rdy_mode = 0;
    int stall_seen = 0;
    int stall_bad  = 0;
    logic [7:0]  lfsr = 8'h5B;
    logic [31:0] imem [0:1023];
    logic        pend = 1'b0;
    logic [15:0] pa;
    logic [31:0] pd;

    always #10 clk = ~clk;

    boot_copy_engine u_boot_copy_engine (
        .clk, .rst_n, .reg_wr, .reg_addr, .reg_wdata, .reg_rdata,
        .pwr_up, .imem_we, .imem_addr, .imem_wdata, .imem_ready
    );

    // instruction-memory model and stall monitor
    always @(posedge clk) begin
        if (imem_we && imem_ready) begin
            imem[imem_addr[11:2]] <= imem_wdata;
            wcnt <= wcnt + 1;
        end
        if (pend) begin
            stall_seen <= stall_seen + 1;
            if (!imem_we || imem_addr != pa || imem_wdata != pd) stall_bad <= stall_bad + 1;
        end
        pend <= imem_we && !imem_ready;
        pa   <= imem_addr;
        pd   <= imem_wdata;
    end

    always @(negedge clk) begin
        lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        case (rdy_mode)
            1:       imem_ready <= lfsr[0] & lfsr[2];
            2:       imem_ready <= 1'b0;
            default: imem_ready <= 1'b1;
        endcase
    end

    function automatic logic [31:0] pat(input int i);
        return {8'hA5, 8'(i), 16'(i * 37 + 5)};
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic bus_rd(input logic [11:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic wait_idle();
        logic [31:0] v;
        for (int k = 0; k < 3000; k++) begin
            @(negedge clk);
            bus_rd(12'h000, v);
            if (!v[31]) break;
        end
    endtask

    task automatic pulse_pwr();
        @(negedge clk); pwr_up = 1'b1;
        @(negedge clk); pwr_up = 1'b0;
    endtask

    task automatic cmp_words(input int src_w, input int dst_b, input int n, input string req);
        int bad = 0;
        logic [31:0] got = '0, exp = '0;
        for (int i = 0; i < n; i++) begin
            if (imem[(dst_b / 4 + i) % 1024] !== pat((src_w + i) % 256)) begin
                if (bad == 0) begin
                    got = imem[(dst_b / 4 + i) % 1024];
                    exp = pat((src_w + i) % 256);
                end
                bad++;
            end
        end
        check(bad == 0, req, got, exp);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        bus_rd(12'h000, v); check(v == 0, "R1 ctrl", v, 0);
        bus_rd(12'h010, v); check(v == 0, "R1 status", v, 0);
        check(imem_we == 0, "R1 imem_we", 32'(imem_we), 0);
    endtask

    task automatic t_ram();
        logic [31:0] v;
        int bad = 0;
        for (int i = 0; i < 256; i++) bus_wr(12'h400 + 12'(i * 4), pat(i));
        for (int i = 0; i < 256; i++) begin
            bus_rd(12'h400 + 12'(i * 4), v);
            if (v != pat(i)) bad++;
        end
        check(bad == 0, "R9 window readback", 32'(bad), 0);
    endtask

    task automatic t_basic();
        logic [31:0] v;
        int w0;
        w0 = wcnt;
        bus_wr(12'h004, 32'h010);
        bus_wr(12'h008, 32'h100);
        bus_wr(12'h00C, 32'd8);
        bus_wr(12'h000, 32'h8000_0000);
        bus_rd(12'h000, v); check(v[31] == 1, "R2 go reads busy", v, 32'h8000_0000);
        bus_rd(12'h010, v); check(v[0] == 0, "R4 done low while running", v, 0);
        wait_idle();
        bus_rd(12'h000, v); check(v == 0, "R2 go self-clears", v, 0);
        bus_rd(12'h010, v); check(v == 1, "R4 done set", v, 1);
        check(wcnt - w0 == 8, "R3 word count", 32'(wcnt - w0), 8);
        cmp_words(4, 'h100, 8, "R3 data/addresses");
        bus_rd(12'h410, v); check(v == pat(4), "R9 retention unchanged", v, pat(4));
    endtask

    task automatic t_wrap();
        int w0;
        w0 = wcnt;
        bus_wr(12'h004, 32'h3F8);
        bus_wr(12'h008, 32'h180);
        bus_wr(12'h00C, 32'd4);
        bus_wr(12'h000, 32'h8000_0000);
        wait_idle();
        check(wcnt - w0 == 4, "R3 wrap count", 32'(wcnt - w0), 4);
        cmp_words(254, 'h180, 4, "R3 source wraps");
    endtask

    task automatic t_zero();
        logic [31:0] v;
        int w0;
        w0 = wcnt;
        bus_wr(12'h00C, 32'd0);
        bus_wr(12'h000, 32'h8000_0000);
        bus_rd(12'h010, v); check(v == 0, "R4 done cleared at start", v, 0);
        @(negedge clk);
        bus_rd(12'h000, v); check(v == 0, "R5 zero count idle after one cycle", v, 0);
        bus_rd(12'h010, v); check(v == 1, "R5 zero count done", v, 1);
        repeat (3) @(negedge clk);
        check(wcnt == w0, "R5 no writes", 32'(wcnt - w0), 0);
    endtask

    task automatic t_stall();
        int w0, s0;
        w0 = wcnt; s0 = stall_seen;
        rdy_mode = 1;
        bus_wr(12'h004, 32'h020);
        bus_wr(12'h008, 32'h600);
        bus_wr(12'h00C, 32'd24);
        bus_wr(12'h000, 32'h8000_0000);
        wait_idle();
        rdy_mode = 0;
        check(stall_bad == 0 && stall_seen > s0, "R6 held under stall", 32'(stall_bad), 0);
        check(wcnt - w0 == 24, "R6 count under stall", 32'(wcnt - w0), 24);
        cmp_words(8, 'h600, 24, "R6 data under stall");
    endtask

    task automatic t_locked();
        logic [31:0] v;
        int w0;
        rdy_mode = 2;
        bus_wr(12'h004, 32'h050);
        bus_wr(12'h008, 32'h200);
        bus_wr(12'h00C, 32'd5);
        w0 = wcnt;
        bus_wr(12'h000, 32'h8000_0000);
        bus_wr(12'h004, 32'h000);
        bus_wr(12'h008, 32'h300);
        bus_wr(12'h00C, 32'd3);
        bus_wr(12'h000, 32'h8000_0000);
        bus_rd(12'h004, v); check(v == 32'h050, "R7 src locked", v, 32'h050);
        bus_rd(12'h008, v); check(v == 32'h200, "R7 dst locked", v, 32'h200);
        bus_rd(12'h00C, v); check(v == 32'd5, "R7 cnt locked", v, 5);
        rdy_mode = 0;
        wait_idle();
        check(wcnt - w0 == 5, "R2 no restart during copy", 32'(wcnt - w0), 5);
        cmp_words(20, 'h200, 5, "R7 copy used old values");
    endtask

    task automatic t_auto();
        logic [31:0] v;
        int w0;
        bus_wr(12'h000, 32'h4000_0000);
        bus_rd(12'h000, v); check(v == 32'h4000_0000, "R8 enable readback", v, 32'h4000_0000);
        bus_wr(12'h004, 32'h000);
        bus_wr(12'h008, 32'h800);
        bus_wr(12'h00C, 32'd3);
        w0 = wcnt;
        pulse_pwr();
        bus_rd(12'h000, v); check(v[31] == 1, "R8 pulse launches", v, 32'hC000_0000);
        wait_idle();
        check(wcnt - w0 == 3, "R8 auto count", 32'(wcnt - w0), 3);
        cmp_words(0, 'h800, 3, "R8 auto data");
        bus_wr(12'h000, 32'h0);
        w0 = wcnt;
        pulse_pwr();
        bus_rd(12'h000, v); check(v == 0, "R8 disabled pulse ignored", v, 0);
        repeat (5) @(negedge clk);
        bus_rd(12'h010, v); check(v == 1, "R8 done untouched", v, 1);
        check(wcnt == w0, "R8 no writes when disabled", 32'(wcnt - w0), 0);
    endtask

    task automatic summary();
        $display("test done: total=%0d bad=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        #(20 * 150000);
        checks++; fails++;
        $display("FAIL watchdog: actual=running expected=finished");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_ram();
        t_basic();
        t_wrap();
        t_zero();
        t_stall();
        t_locked();
        t_auto();
        summary();
    end
endmodule